// File: doc/BRIEF.md
# Indirect Configuration Address/Data Bridge

This block lets a processor reach a device configuration space through two four-byte windows on a single host request stream. A full-word write to the address window loads a 32-bit selector word. The top bit of that word enables configuration access. The word also holds a bus number in bits 23:16, a device/function number in bits 15:8 and a byte offset in bits 7:0. An access to the data window is turned into one request on a downstream configuration bus. Read data comes back from that bus and is returned to the host.

The effective offset of a data access is the selector word's offset field ORed with the low two bits of the access address. The downstream length is clamped so that no transfer runs past byte 255 of the 256-byte space. If the enable bit is clear, or the width is not supported, no downstream request is made. Reads in those cases return all ones.

Host requests and responses use valid/ready. A request is accepted only in a cycle where `host_req_ready` is high, and `host_req_ready` is low from acceptance until the response has been taken. A response stays on `host_rsp_valid` with stable data until `host_rsp_ready` is seen high at a clock edge. The downstream side is a one-cycle request pulse answered by a one-cycle `cfg_rsp_ready` pulse. That pulse may come as early as the request cycle itself.

Top module: `cfgb_bridge`

## Requirements
- R1: After reset the selector word is 0: an address-window read returns 0x00000000, and data accesses are disabled.
- R2: A write of size 4 to the address window (`host_req_win`=0) loads all 32 bits of the selector word. A read of size 4 from the address window returns the full word, whether bit 31 is set or clear.
- R3: An address-window access whose size is not 4 leaves the selector word unchanged. If that access is a read, it returns 0xFFFFFFFF.
- R4: With bit 31 set, a data-window access (`host_req_win`=1) of size 1, 2 or 4 produces exactly one `cfg_req_valid` pulse, one clock cycle long, in the cycle after acceptance. The pulse carries:
  - bus = word[23:16];
  - devfn = word[15:8];
  - offset = word[7:0] OR `host_req_lo`;
  - the write flag and the write data of the access.
- R5: `cfg_req_len` is the lesser of the access size and (256 − offset). Its value is a byte count from 1 to 4.
- R6: With bit 31 clear, a data-window read or write issues no downstream request. The read returns all ones in the low `size` bytes and zero in the bytes above them.
- R7: A data-window access whose size is not 1, 2 or 4 issues no downstream request. If that access is a read, it returns 0xFFFFFFFF.
- R8: A forwarded read returns `cfg_rsp_rdata` with only its low `cfg_req_len` bytes kept and the bytes above them zeroed. If `cfg_rsp_absent` is high with the response, the read instead returns all ones in the low `size` bytes.
- R9: A pending response holds `host_rsp_valid` and `host_rsp_rdata` stable until `host_rsp_ready` is high. `host_req_ready` is low while a response is pending. Every write response carries data 0.
- R10: A downstream response whose `cfg_rsp_ready` is high in the same cycle as `cfg_req_valid` is accepted. The read then completes with the same data as one that arrives later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Bridge can accept a request |
| host_req_win | input | 1 | 0 = address window, 1 = data window |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_lo | input | 2 | Low two bits of the window access address |
| host_req_size | input | 3 | Access size in bytes |
| host_req_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Response valid |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Read data (0 for writes) |
| cfg_req_valid | output | 1 | Downstream request pulse |
| cfg_req_write | output | 1 | Downstream write flag |
| cfg_req_bus | output | 8 | Bus number |
| cfg_req_devfn | output | 8 | Device/function number |
| cfg_req_offset | output | 8 | Byte offset in the configuration space |
| cfg_req_len | output | 3 | Clamped length in bytes |
| cfg_req_wdata | output | 32 | Downstream write data |
| cfg_rsp_ready | input | 1 | Downstream read response pulse |
| cfg_rsp_rdata | input | 32 | Downstream read data |
| cfg_rsp_absent | input | 1 | Target device does not exist |

## Verification
Two pairs of events can fall in the same cycle.

- **Downstream reply in the issue cycle.** The downstream reply can come in the same cycle as the request pulse. The bench provokes this with a zero-latency responder on alternate offsets of the sweep. Each read is judged against the arithmetically expected masked data, and the result must match the delayed-responder case exactly.
- **Back-pressure against a completed response.** Host back-pressure can meet a response that has just completed. The bench holds `host_rsp_ready` low for several cycles on selected accesses. It requires that the response data stays unchanged and that `host_req_ready` stays low for that whole time.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } cfgb_state_t;
endpackage

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch #(
  parameter int WORD_W    = 32,
  parameter int FIELD_W   = 8,
  parameter int EN_BIT    = 31,
  parameter int BUS_LSB   = 16,
  parameter int DEVFN_LSB = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_i,
  input  logic [WORD_W-1:0]  ld_data_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               en_o,
  output logic [FIELD_W-1:0] bus_o,
  output logic [FIELD_W-1:0] devfn_o,
  output logic [FIELD_W-1:0] off_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (ld_i) word_q <= ld_data_i;
  end

  assign word_o  = word_q;
  assign en_o    = word_q[EN_BIT];
  assign bus_o   = word_q[BUS_LSB +: FIELD_W];
  assign devfn_o = word_q[DEVFN_LSB +: FIELD_W];
  assign off_o   = word_q[FIELD_W-1:0];

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(word_q));
endmodule

// File: rtl/cfgb_compose.sv
module cfgb_compose #(
  parameter int SPACE_BYTES = 256,
  parameter int MAX_BYTES   = 4,
  parameter int LO_W        = 2,
  localparam int OFF_W = $clog2(SPACE_BYTES),
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic [OFF_W-1:0] base_off_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic [LEN_W-1:0] size_i,
  output logic [OFF_W-1:0] off_o,
  output logic [LEN_W-1:0] len_o,
  output logic             size_ok_o
);
  logic [OFF_W:0] room;
  logic [OFF_W:0] size_ext;

  assign off_o    = base_off_i | OFF_W'(lo_i);
  assign room     = (OFF_W+1)'(SPACE_BYTES) - {1'b0, off_o};
  assign size_ext = (OFF_W+1)'(size_i);
  assign len_o    = (size_ext < room) ? size_i : LEN_W'(room);

  // a supported size is a power of two no larger than MAX_BYTES
  assign size_ok_o = (size_i != '0) && ((size_i & (size_i - 1'b1)) == '0)
                     && (int'(size_i) <= MAX_BYTES);
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int FIELD_W   = 8,
  parameter int MAX_BYTES = 4,
  parameter int EN_BIT    = 31,
  localparam int LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int NBYTES = WORD_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_win_i,
  input  logic               req_write_i,
  input  logic [LEN_W-1:0]   req_size_i,
  input  logic [WORD_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [WORD_W-1:0]  rsp_rdata_o,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] bus_i,
  input  logic [FIELD_W-1:0] devfn_i,
  input  logic [FIELD_W-1:0] off_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               size_ok_i,
  output logic               ld_o,
  output logic [WORD_W-1:0]  ld_data_o,
  output logic               cfg_valid_o,
  output logic               cfg_write_o,
  output logic [FIELD_W-1:0] cfg_bus_o,
  output logic [FIELD_W-1:0] cfg_devfn_o,
  output logic [FIELD_W-1:0] cfg_off_o,
  output logic [LEN_W-1:0]   cfg_len_o,
  output logic [WORD_W-1:0]  cfg_wdata_o,
  input  logic               cfg_rsp_ready_i,
  input  logic [WORD_W-1:0]  cfg_rsp_rdata_i,
  input  logic               cfg_rsp_absent_i
);
  cfgb_state_t        state_q;
  logic               wr_q;
  logic [FIELD_W-1:0] bus_q, devfn_q, off_q;
  logic [LEN_W-1:0]   len_q, size_q;
  logic [WORD_W-1:0]  wdata_q, rsp_q;
  logic               accept;
  logic               addr_size_ok;
  logic               capture;

  function automatic logic [WORD_W-1:0] byte_mask(input logic [LEN_W-1:0] n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (i < int'(n)) m[i*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  assign req_ready_o  = (state_q == ST_IDLE);
  assign accept       = req_valid_i && req_ready_o;
  assign addr_size_ok = (int'(req_size_i) == NBYTES);
  assign ld_o         = accept && !req_win_i && req_write_i && addr_size_ok;
  assign ld_data_o    = req_wdata_i;
  assign capture      = !wr_q && cfg_rsp_ready_i &&
                        ((state_q == ST_ISSUE) || (state_q == ST_WAIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      bus_q   <= '0;
      devfn_q <= '0;
      off_q   <= '0;
      len_q   <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            wr_q    <= req_write_i;
            size_q  <= req_size_i;
            bus_q   <= bus_i;
            devfn_q <= devfn_i;
            off_q   <= off_i;
            len_q   <= len_i;
            wdata_q <= req_wdata_i;
            if (!req_win_i) begin
              if (req_write_i)       rsp_q <= '0;
              else if (addr_size_ok) rsp_q <= word_i;
              else                   rsp_q <= '1;
              state_q <= ST_RESP;
            end else if (!size_ok_i) begin
              rsp_q   <= req_write_i ? '0 : '1;
              state_q <= ST_RESP;
            end else if (!en_i) begin
              rsp_q   <= req_write_i ? '0 : byte_mask(req_size_i);
              state_q <= ST_RESP;
            end else begin
              rsp_q   <= '0;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (wr_q)         state_q <= ST_RESP;
          else if (capture) state_q <= ST_RESP;
          else              state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (capture) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (capture) begin
        rsp_q <= cfg_rsp_absent_i ? byte_mask(size_q)
                                  : (cfg_rsp_rdata_i & byte_mask(len_q));
      end
    end
  end

  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_rdata_o = rsp_q;
  assign cfg_valid_o = (state_q == ST_ISSUE);
  assign cfg_write_o = wr_q;
  assign cfg_bus_o   = bus_q;
  assign cfg_devfn_o = devfn_q;
  assign cfg_off_o   = off_q;
  assign cfg_len_o   = len_q;
  assign cfg_wdata_o = wdata_q;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o));
  // R9
  busy_noaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid_o && req_ready_o));
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |=> !cfg_valid_o);
  // R9
  wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && wr_q |-> rsp_rdata_o == '0);
endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge #(
  parameter int WORD_W      = 32,
  parameter int FIELD_W     = 8,
  parameter int SPACE_BYTES = 256,
  parameter int MAX_BYTES   = 4,
  parameter int LO_W        = 2,
  parameter int EN_BIT      = 31,
  parameter int BUS_LSB     = 16,
  parameter int DEVFN_LSB   = 8,
  localparam int OFF_W = $clog2(SPACE_BYTES),
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req_valid,
  output logic               host_req_ready,
  input  logic               host_req_win,
  input  logic               host_req_write,
  input  logic [LO_W-1:0]    host_req_lo,
  input  logic [LEN_W-1:0]   host_req_size,
  input  logic [WORD_W-1:0]  host_req_wdata,
  output logic               host_rsp_valid,
  input  logic               host_rsp_ready,
  output logic [WORD_W-1:0]  host_rsp_rdata,
  output logic               cfg_req_valid,
  output logic               cfg_req_write,
  output logic [FIELD_W-1:0] cfg_req_bus,
  output logic [FIELD_W-1:0] cfg_req_devfn,
  output logic [OFF_W-1:0]   cfg_req_offset,
  output logic [LEN_W-1:0]   cfg_req_len,
  output logic [WORD_W-1:0]  cfg_req_wdata,
  input  logic               cfg_rsp_ready,
  input  logic [WORD_W-1:0]  cfg_rsp_rdata,
  input  logic               cfg_rsp_absent
);
  logic [WORD_W-1:0]  word, ld_data;
  logic               ld, en;
  logic [FIELD_W-1:0] bus, devfn, base_off;
  logic [OFF_W-1:0]   off;
  logic [LEN_W-1:0]   len;
  logic               size_ok;

  cfgb_addr_latch #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W), .EN_BIT(EN_BIT),
    .BUS_LSB(BUS_LSB), .DEVFN_LSB(DEVFN_LSB)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_data_i(ld_data),
    .word_o(word), .en_o(en), .bus_o(bus), .devfn_o(devfn), .off_o(base_off)
  );

  cfgb_compose #(
    .SPACE_BYTES(SPACE_BYTES), .MAX_BYTES(MAX_BYTES), .LO_W(LO_W)
  ) u_comp (
    .base_off_i(OFF_W'(base_off)), .lo_i(host_req_lo), .size_i(host_req_size),
    .off_o(off), .len_o(len), .size_ok_o(size_ok)
  );

  cfgb_ctrl #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W), .MAX_BYTES(MAX_BYTES), .EN_BIT(EN_BIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(host_req_valid), .req_ready_o(host_req_ready),
    .req_win_i(host_req_win), .req_write_i(host_req_write),
    .req_size_i(host_req_size), .req_wdata_i(host_req_wdata),
    .rsp_valid_o(host_rsp_valid), .rsp_ready_i(host_rsp_ready),
    .rsp_rdata_o(host_rsp_rdata),
    .word_i(word), .en_i(en), .bus_i(bus), .devfn_i(devfn),
    .off_i(FIELD_W'(off)), .len_i(len), .size_ok_i(size_ok),
    .ld_o(ld), .ld_data_o(ld_data),
    .cfg_valid_o(cfg_req_valid), .cfg_write_o(cfg_req_write),
    .cfg_bus_o(cfg_req_bus), .cfg_devfn_o(cfg_req_devfn),
    .cfg_off_o(cfg_req_offset), .cfg_len_o(cfg_req_len),
    .cfg_wdata_o(cfg_req_wdata),
    .cfg_rsp_ready_i(cfg_rsp_ready), .cfg_rsp_rdata_i(cfg_rsp_rdata),
    .cfg_rsp_absent_i(cfg_rsp_absent)
  );

  // R6
  gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> en);
  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_len != '0) &&
      (({1'b0, cfg_req_offset} + (OFF_W+1)'(cfg_req_len)) <= (OFF_W+1)'(SPACE_BYTES)));
endmodule

// File: tb/sim_cfgb_bridge.sv
module sim_cfgb_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0, host_req_win = 1'b0, host_req_write = 1'b0;
  logic [1:0]  host_req_lo = '0;
  logic [2:0]  host_req_size = '0;
  logic [31:0] host_req_wdata = '0;
  logic        host_req_ready, host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic [7:0]  cfg_req_bus, cfg_req_devfn, cfg_req_offset;
  logic [2:0]  cfg_req_len;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_ready, cfg_rsp_absent;
  logic [31:0] cfg_rsp_rdata;

  int checks = 0, errors = 0, nreq = 0;
  logic lat0 = 1'b1;
  logic dly_rdy = 1'b0, held_abs = 1'b0;
  logic [31:0] held_data = '0;
  logic [7:0]  m_bus, m_devfn, m_off;
  logic [2:0]  m_len;
  logic        m_wr;
  logic [31:0] m_wdata;
  bit done = 0;

  always #4 clk = ~clk;

  cfgb_bridge u0 (.*);

  function automatic logic [31:0] model_word(logic [7:0] b, logic [7:0] d, logic [7:0] o);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[i*8 +: 8] = (o + 8'(i)) ^ d ^ {b[6:0], 1'b0} ^ 8'h5A;
    return w;
  endfunction

  function automatic logic [31:0] mask_of(int n);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (i < n) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  assign cfg_rsp_ready  = lat0 ? (cfg_req_valid && !cfg_req_write) : dly_rdy;
  assign cfg_rsp_rdata  = lat0 ? model_word(cfg_req_bus, cfg_req_devfn, cfg_req_offset) : held_data;
  assign cfg_rsp_absent = lat0 ? (cfg_req_bus == 8'hEE) : held_abs;

  always @(negedge clk) begin
    if (rst_n && cfg_req_valid) begin
      nreq++;
      m_bus = cfg_req_bus; m_devfn = cfg_req_devfn; m_off = cfg_req_offset;
      m_len = cfg_req_len; m_wr = cfg_req_write; m_wdata = cfg_req_wdata;
    end
  end

  always begin
    @(negedge clk);
    if (rst_n && !lat0 && cfg_req_valid && !cfg_req_write) begin
      held_data = model_word(cfg_req_bus, cfg_req_devfn, cfg_req_offset);
      held_abs  = (cfg_req_bus == 8'hEE);
      repeat (2) @(negedge clk);
      dly_rdy = 1'b1;
      @(negedge clk);
      dly_rdy = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic win, input logic wr, input logic [1:0] lo,
                        input logic [2:0] sz, input logic [31:0] wd, input int hold,
                        output logic [31:0] rd);
    logic [31:0] first;
    int guard;
    @(negedge clk);
    host_req_win = win; host_req_write = wr; host_req_lo = lo;
    host_req_size = sz; host_req_wdata = wd; host_req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    guard = 0;
    while (!host_rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    if (hold > 0) begin
      first = host_rsp_rdata;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(host_rsp_valid && host_rsp_rdata == first && !host_req_ready,
            "R9 hold", host_rsp_rdata, first);
      end
    end
    host_rsp_ready = 1'b1;
    rd = host_rsp_rdata;
    @(negedge clk);
    host_rsp_ready = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(host_req_ready && !host_rsp_valid && !cfg_req_valid, "R1 reset pins",
        {29'b0, host_req_ready, host_rsp_valid, cfg_req_valid}, 32'h4);
    access(1'b0, 1'b0, 2'd0, 3'd4, '0, 0, rd);
    chk(rd == 32'h0, "R1 word after reset", rd, 32'h0);

    // R6 disabled reads/writes
    for (int s = 1; s <= 4; s = s * 2) begin
      n0 = nreq;
      access(1'b1, 1'b0, 2'd1, 3'(s), '0, 0, rd);
      chk(rd == mask_of(s) && nreq == n0, "R6 disabled read", rd, mask_of(s));
      access(1'b1, 1'b1, 2'd0, 3'(s), 32'h1234_5678, 0, rd);
      chk(rd == 32'h0 && nreq == n0, "R6 disabled write", 32'(nreq - n0), 32'h0);
    end

    // R2 readback with enable clear
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h00AB_1234, 0, rd);
    access(1'b0, 1'b0, 2'd0, 3'd4, '0, 0, rd);
    chk(rd == 32'h00AB_1234, "R2 readback disabled", rd, 32'h00AB_1234);
    n0 = nreq;
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, 0, rd);
    chk(rd == 32'hFFFF_FFFF && nreq == n0, "R6 still disabled", rd, 32'hFFFF_FFFF);

    // R3 sub-word address window accesses
    access(1'b0, 1'b1, 2'd0, 3'd2, 32'hDEAD_BEEF, 0, rd);
    access(1'b0, 1'b1, 2'd0, 3'd1, 32'h8000_0000, 0, rd);
    access(1'b0, 1'b0, 2'd0, 3'd4, '0, 0, rd);
    chk(rd == 32'h00AB_1234, "R3 word unchanged", rd, 32'h00AB_1234);
    access(1'b0, 1'b0, 2'd0, 3'd1, '0, 0, rd);
    chk(rd == 32'hFFFF_FFFF, "R3 narrow read", rd, 32'hFFFF_FFFF);

    // R7 unsupported data widths with enable set
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8012_1300, 0, rd);
    for (int s = 0; s < 8; s++) begin
      if (s != 1 && s != 2 && s != 4) begin
        n0 = nreq;
        access(1'b1, 1'b0, 2'd0, 3'(s), '0, 0, rd);
        chk(rd == 32'hFFFF_FFFF && nreq == n0, "R7 bad width read", rd, 32'hFFFF_FFFF);
        access(1'b1, 1'b1, 2'd0, 3'(s), 32'h55, 0, rd);
        chk(nreq == n0, "R7 bad width write", 32'(nreq - n0), 32'h0);
      end
    end

    // R8 absent device, both responder latencies
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h80EE_0810, 0, rd);
    lat0 = 1'b0;
    access(1'b1, 1'b0, 2'd1, 3'd2, '0, 0, rd);
    chk(rd == 32'h0000_FFFF, "R8 absent size2", rd, 32'h0000_FFFF);
    lat0 = 1'b1;
    access(1'b1, 1'b0, 2'd0, 3'd4, '0, 0, rd);
    chk(rd == 32'hFFFF_FFFF, "R10 absent same cycle", rd, 32'hFFFF_FFFF);

    // R9 back-pressure on forwarded read and on write
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8003_0540, 0, rd);
    access(1'b1, 1'b0, 2'd2, 3'd4, '0, 3, rd);
    exp = model_word(8'h03, 8'h05, 8'h42);
    chk(rd == exp, "R9 held read data", rd, exp);
    access(1'b1, 1'b1, 2'd0, 3'd2, 32'hCAFE, 4, rd);
    chk(rd == 32'h0, "R9 write rsp zero", rd, 32'h0);

    // Sweep of every offset, low bits, width and direction
    for (int off = 0; off < 256; off++) begin
      logic [7:0] bus, dfn;
      logic [31:0] w;
      bus = 8'h3C; dfn = 8'(off) ^ 8'h81;
      w = {8'h80, bus, dfn, 8'(off)};
      access(1'b0, 1'b1, 2'd0, 3'd4, w, 0, rd);
      access(1'b0, 1'b0, 2'd0, 3'd4, '0, 0, rd);
      chk(rd == w, "R2 readback", rd, w);
      lat0 = (off % 2 == 0);
      for (int lo = 0; lo < 4; lo++) begin
        for (int si = 0; si < 3; si++) begin
          for (int wr = 0; wr < 2; wr++) begin
            int sz, eoff, elen;
            logic [31:0] wd;
            sz = 1 << si;
            eoff = off | lo;
            elen = (sz < 256 - eoff) ? sz : 256 - eoff;
            wd = 32'hA000_0000 | 32'(off << 8) | 32'(lo * 16 + si * 2 + wr);
            n0 = nreq;
            access(1'b1, 1'(wr), 2'(lo), 3'(sz), wd, 0, rd);
            chk(nreq == n0 + 1, "R4 one request", 32'(nreq - n0), 32'h1);
            chk(m_bus == bus && m_devfn == dfn && m_off == 8'(eoff) && m_wr == 1'(wr)
                && (wr == 0 || m_wdata == wd),
                "R4 fields", {m_bus, m_devfn, m_off, 7'b0, m_wr},
                {bus, dfn, 8'(eoff), 7'b0, 1'(wr)});
            chk(int'(m_len) == elen, "R5 length", 32'(m_len), 32'(elen));
            if (wr == 1) begin
              chk(rd == 32'h0, "R9 write data zero", rd, 32'h0);
            end else begin
              exp = model_word(bus, dfn, 8'(eoff)) & mask_of(elen);
              chk(rd == exp, lat0 ? "R10 same-cycle read" : "R8 masked read", rd, exp);
            end
          end
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule